// File: doc/BRIEF.md
# Modem Status Register with Change Detection

This block is the modem-status register of a serial port. It takes four active-low handshake inputs from the line side: clear-to-send, data-set-ready, ring indicator and carrier detect. It reports their current levels and a change flag for each through an 8-bit CPU read port. The CPU reads the register to learn the line state. The read also clears the change flags. A level interrupt stays raised while any change flag is pending.

In loopback mode the block ignores the external pins. It reports four of the port's own modem-control outputs in their place, and the change flags follow those outputs instead. The read address is shared with a write-only feature-control byte. A write at that address stores the byte, which the block drives out on a port, and leaves the status untouched.

Top module: `modem_status_reg`

## Requirements
- R1: After reset, all four change flags (read bits 3:0) read 0, the interrupt is low and the feature-control byte is 0x00.
- R2: Outside loopback, the inputs are mapped as follows: `modem_in_n[0]` is clear-to-send, `[1]` is data-set-ready, `[2]` is ring and `[3]` is carrier. Read bits 4, 5, 6 and 7 return the inverted clear-to-send, data-set-ready, ring and carrier inputs, each after a two-flop synchronizer.
- R3: In loopback, `mctl_q[0]`=DTR, `[1]`=RTS, `[2]`=OP1 and `[3]`=OP2. Bit 7 returns OP2, bit 6 returns OP1, bit 5 returns DTR and bit 4 returns RTS. The external pins have no effect.
- R4: Bits 0, 1 and 3 are the change flags of bits 4, 5 and 7. Each one sets when its level bit changes in either direction.
- R5: Bit 2 sets only when the reported ring level (bit 6) falls from 1 to 0, which is a rise of the ring pin. The opposite transition leaves it clear.
- R6: A read (`rd_en` high at a clock edge) clears all four change flags at that edge. The data returned is the value before the clear.
- R7: A qualifying change detected in the same cycle as a clearing read leaves its flag set for the next read.
- R8: `irq` is high exactly when `irq_en` is high and at least one change flag is set.
- R9: A write stores `wdata` in the feature-control byte at the next edge. A write changes neither the levels nor the change flags, and a read never returns the feature-control byte.
- R10: Entering or leaving loopback sets a change flag for every bit whose reported level differs between the two sources, following the R4/R5 rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| modem_in_n | input | 4 | Active-low handshake pins (asynchronous) |
| loopback_en | input | 1 | Loopback mode select |
| mctl_q | input | 4 | Modem-control outputs: DTR, RTS, OP1, OP2 |
| rd_en | input | 1 | Read strobe for the shared address |
| wr_en | input | 1 | Write strobe for the shared address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Status: levels in 7:4, change flags in 3:0 |
| efc_q | output | 8 | Stored feature-control byte |
| irq_en | input | 1 | Modem-status interrupt enable |
| irq | output | 1 | Level modem-status interrupt |

## Verification
A clearing read and a freshly detected pin edge can fall in the same clock cycle. The read must then return the old flags while the new edge survives the clear.

The bench provokes this by toggling the clear-to-send pin and issuing the read exactly two edges later, when the synchronized edge reaches the detector. It expects the level bit alone in that read and the change flag in the following one. Loopback entry and exit are also driven with differing sources, so that a mode switch and a read can be judged as separate events.

// File: rtl/modem_status_reg.sv
module modem_status_reg #(
  parameter int SYNC_STAGES = 2,
  parameter int NSIG        = 4,
  parameter int DW          = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] modem_in_n,
  input  logic            loopback_en,
  input  logic [NSIG-1:0] mctl_q,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [DW-1:0]   efc_q,
  input  logic            irq_en,
  output logic            irq
);
  localparam int RI = 2;

  logic [NSIG-1:0] sync_q [SYNC_STAGES];
  logic [NSIG-1:0] pin_lvl, loop_lvl, eff, eff_q, chg, set_v, delta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '1;
    end else begin
      sync_q[0] <= modem_in_n;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  // order [3]=carrier [2]=ring [1]=data-set-ready [0]=clear-to-send
  assign pin_lvl  = ~sync_q[SYNC_STAGES-1];
  assign loop_lvl = {mctl_q[3], mctl_q[2], mctl_q[0], mctl_q[1]};
  assign eff      = loopback_en ? loop_lvl : pin_lvl;

  assign chg   = eff ^ eff_q;
  always_comb begin
    set_v     = chg;
    set_v[RI] = chg[RI] & eff_q[RI];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q   <= '0;
      delta_q <= '0;
      efc_q   <= '0;
    end else begin
      eff_q   <= eff;
      delta_q <= (rd_en ? '0 : delta_q) | set_v;
      if (wr_en) efc_q <= wdata;
    end
  end

  assign rdata = {eff, delta_q};
  assign irq   = irq_en & (|delta_q);

  // R6: a read with no change pending leaves all flags clear
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && eff == eff_q) |=> (rdata[3:0] == '0));
  // R7: an edge coinciding with a read survives it
  a_r7_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && chg[0]) |=> rdata[0]);
  // R5: a rise of the ring level never sets its flag
  a_r5_ri_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (!delta_q[RI] && !eff_q[RI] && eff[RI]) |=> !rdata[RI]);
  // R8: interrupt follows enable and pending flags
  a_r8_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && rdata[3:0] != '0) |-> irq);
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[3:0] == '0 || !irq_en) |-> !irq);
  // R9: write captures data, flags unaffected without read
  a_r9_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> efc_q == $past(wdata));
  a_r9_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && delta_q[0]) |=> rdata[0]);
endmodule

// File: tb/sim_modem_status_reg.sv
module sim_modem_status_reg;
  localparam int CLK_P = 10;

  logic       clk = 0, rst_n = 0;
  logic [3:0] modem_in_n = 4'hF, mctl_q = 4'h0;
  logic       loopback_en = 0, rd_en = 0, wr_en = 0, irq_en = 1;
  logic [7:0] wdata = 0, rdata, efc_q;
  logic       irq;

  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       mon_ev;

  always #(CLK_P/2) clk = ~clk;

  modem_status_reg u0 (
    .clk(clk), .rst_n(rst_n), .modem_in_n(modem_in_n), .loopback_en(loopback_en),
    .mctl_q(mctl_q), .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .efc_q(efc_q), .irq_en(irq_en), .irq(irq));

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(mon_ev);
    check(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic do_read(logic [7:0] exp, string tag);
    rd_en = 1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    #(CLK_P/4) -> mon_ev;
    @(negedge clk) rd_en = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_P*100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 efc", efc_q, 8'h00);
    do_read(8'h00, "R1 status");

    modem_in_n = 4'b1110; settle();
    check("R8 irq set", {7'd0, irq}, 8'h01);
    do_read(8'h11, "R2/R4 cts fall");
    do_read(8'h10, "R6 cleared");
    modem_in_n = 4'b1111; settle();
    do_read(8'h01, "R4 cts rise");
    do_read(8'h00, "R6 cleared2");

    modem_in_n = 4'b1011; settle();
    do_read(8'h40, "R5 ring no flag");
    modem_in_n = 4'b1111; settle();
    do_read(8'h04, "R5 ring flag");
    do_read(8'h00, "R6 cleared3");

    modem_in_n = 4'b0101; settle();
    do_read(8'hAA, "R2/R4 cd dsr");
    do_read(8'hA0, "R6 cleared4");
    modem_in_n = 4'b1111; settle();
    do_read(8'h0A, "R4 cd dsr back");
    do_read(8'h00, "R6 cleared5");

    irq_en = 0;
    modem_in_n = 4'b1110; settle();
    check("R8 irq gated", {7'd0, irq}, 8'h00);
    irq_en = 1; #1;
    check("R8 irq enabled", {7'd0, irq}, 8'h01);
    wr_en = 1; wdata = 8'hC3;
    @(negedge clk) wr_en = 0;
    check("R9 efc stored", efc_q, 8'hC3);
    do_read(8'h11, "R9 write keeps status");
    do_read(8'h10, "R9 read not efc");
    modem_in_n = 4'b1111; settle();
    do_read(8'h01, "R4 cts rise2");
    do_read(8'h00, "R6 cleared6");
    check("R8 irq low", {7'd0, irq}, 8'h00);

    modem_in_n = 4'b1110;
    repeat (2) @(negedge clk);
    do_read(8'h10, "R7 coincident read");
    do_read(8'h11, "R7 flag kept");
    do_read(8'h10, "R7 cleared");
    modem_in_n = 4'b1111; settle();
    do_read(8'h01, "R7 restore");
    do_read(8'h00, "R7 restore clear");

    loopback_en = 1; settle();
    do_read(8'h00, "R10 same level no flag");
    mctl_q = 4'b0001; settle();
    do_read(8'h22, "R3 dtr->bit5");
    mctl_q = 4'b0010; settle();
    do_read(8'h13, "R3 rts->bit4");
    do_read(8'h10, "R3 cleared");
    mctl_q = 4'b0100; settle();
    do_read(8'h41, "R3 op1->bit6");
    mctl_q = 4'b1000; settle();
    do_read(8'h8C, "R3 op2->bit7");
    do_read(8'h80, "R3 cleared2");
    modem_in_n = 4'b1110; settle();
    do_read(8'h80, "R3 pins ignored");
    loopback_en = 0; settle();
    do_read(8'h19, "R10 leave loopback");
    do_read(8'h10, "R10 cleared");
    modem_in_n = 4'b1111; settle();
    do_read(8'h01, "R10 restore");
    do_read(8'h00, "R10 restore clear");

    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule